// File: doc/BRIEF.md
# Dual-Channel Half-Band 2x Interpolator

This block raises the sample rate of two 12-bit two's complement streams, I and Q, by a factor of two. It uses a fixed 43-tap symmetric half-band low-pass filter. The block runs on one clock at the output rate. An internal slot toggle marks every other edge as a capture edge, which stands in for the input-rate clock. On each capture edge the block takes one word per channel. On every edge it produces one output word per channel, so each channel emits two words for each word it takes.

Every other coefficient of the filter is zero, and the centre coefficient is 16384, which is 2^14. Because of this, one of the two output phases is simply a delayed copy of the input. The other phase is a 22-term symmetric sum. Sample pairs are pre-added before that sum, so each channel needs only eleven constant multiplies. Both phases are scaled by 2^-14, rounded to nearest and clipped to the 12-bit range. A system integrator drives fresh I/Q words while `take_in` is high and reads `dout_i`/`dout_q` every clock. `out_ph` tells which phase the current output word belongs to.

Top module: `halfband_interp2x`

## Requirements
- R1: A synchronous active-high `rst` clears the delay lines and the output registers. One edge after reset is sampled, `dout_i` = `dout_q` = 0, `out_ph` = 0 and `take_in` = 1.
- R2: Out of reset, `take_in` toggles on every clock edge, starting at 1. An edge captures `din_i`/`din_q` exactly when `take_in` was 1 before that edge.
- R3: Centre phase: when `out_ph` = 1, each output equals, unchanged, the input word of that channel captured 22 clock cycles (11 capture slots) earlier. Words captured before reset count as 0.
- R4: Filter phase: when `out_ph` = 0, the output equals sum over p=0..10 of c(p)·(x[n-p] + x[n-21+p]), divided by 16384. Here x[n] is the most recent capture and c = +10, -31, +69, -138, +248, -419, +678, -1083, +1776, -3282, +10364 for p = 0..10.
- R5: Scaling by 2^-14 rounds to nearest, and exact halves round toward +infinity (add 8192, then floor-shift by 14).
- R6: Results outside -2048..2047 are clipped to the nearer limit rather than wrapped.
- R7: `out_ph` is 1 on the word loaded at a capture edge (the centre phase) and 0 on the word loaded at the following edge (the filter phase). The filter-phase word built from capture n therefore appears one cycle after that capture.
- R8: The I and Q channels are processed identically and independently. Data on one channel never changes the other channel's output.
- R9: A constant input v, held long enough to fill the filter, gives v on both output phases (unity DC gain).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output-rate clock, twice the input sample rate |
| rst | input | 1 | Synchronous active-high reset |
| din_i | input | DATA_W | I channel input word, two's complement |
| din_q | input | DATA_W | Q channel input word, two's complement |
| take_in | output | 1 | High when the next rising edge captures the inputs |
| out_ph | output | 1 | Phase of the current output word: 1 centre (delayed copy), 0 filtered |
| dout_i | output | DATA_W | I channel output word, two's complement |
| dout_q | output | DATA_W | Q channel output word, two's complement |

## Verification
The bench builds the block with its default 12-bit data and 16-bit coefficient width. At that size the whole input amplitude range can be swept cheaply with isolated impulses. Each impulse spells out every coefficient, scaled and rounded, at many amplitudes. The value -2048 lands exactly on a rounding half against the 10364 tap. Sign-matched full-scale patterns push the filter phase to about 4500 and so exercise clipping at both rails. A direct 43-tap convolution of the zero-stuffed input, written independently in the bench, predicts every output word on both channels.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

   // number of distinct nonzero outer taps on one side of the centre
   localparam int HB_NHALF     = 11;
   // centre tap is 2**HB_CTR_SHIFT; all taps share that scale
   localparam int HB_CTR_SHIFT = 14;

   // Outer coefficient p (0 = farthest from centre, HB_NHALF-1 = nearest).
   // Signs alternate and are positive next to the centre.
   function automatic int hb_coef(input int p);
      int mag;
      case (p)
         0:  mag = 10;
         1:  mag = 31;
         2:  mag = 69;
         3:  mag = 138;
         4:  mag = 248;
         5:  mag = 419;
         6:  mag = 678;
         7:  mag = 1083;
         8:  mag = 1776;
         9:  mag = 3282;
         10: mag = 10364;
         default: mag = 0;
      endcase
      return (((HB_NHALF - 1 - p) % 2) == 0) ? mag : -mag;
   endfunction

endpackage

// File: rtl/hbi_delay_line.sv
module hbi_delay_line #(
   parameter int DW    = 12,
   parameter int DEPTH = 22
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       shift_en,
   input  logic [DW-1:0]              din,
   output logic [DEPTH-1:0][DW-1:0]   taps
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("hbi_delay_line: DEPTH must be at least 2");
      end
   endgenerate

   // taps[0] holds the newest word, taps[DEPTH-1] the oldest
   always_ff @(posedge clk) begin
      if (rst) begin
         taps <= '0;
      end else if (shift_en) begin
         taps <= {taps[DEPTH-2:0], din};
      end
   end

endmodule

// File: rtl/hbi_polyphase.sv
module hbi_polyphase #(
   parameter int DW    = 12,
   parameter int CW    = 16,
   parameter int NHALF = 11,
   parameter int ACC_W = 33
) (
   input  logic [2*NHALF-1:0][DW-1:0]  taps,
   output logic signed [ACC_W-1:0]     acc
);

   localparam int DEPTH  = 2 * NHALF;
   localparam int PRE_W  = DW + 1;
   localparam int PROD_W = PRE_W + CW;

   generate
      if (ACC_W < PROD_W + $clog2(NHALF)) begin : g_bad_acc
         $error("hbi_polyphase: ACC_W too narrow for the tap sum");
      end
   endgenerate

   logic signed [PRE_W-1:0]  pre  [NHALF];
   logic signed [PROD_W-1:0] prod [NHALF];

   // fold the symmetric pairs, then one constant multiply per pair
   generate
      for (genvar p = 0; p < NHALF; p++) begin : g_tap
         localparam logic signed [CW-1:0] COEF_P = CW'(hbi_pkg::hb_coef(p));
         assign pre[p]  = PRE_W'($signed(taps[p])) + PRE_W'($signed(taps[DEPTH-1-p]));
         assign prod[p] = pre[p] * COEF_P;
      end
   endgenerate

   always_comb begin
      acc = '0;
      for (int p = 0; p < NHALF; p++) begin
         acc = acc + ACC_W'(prod[p]);
      end
   end

endmodule

// File: rtl/hbi_round_sat.sv
module hbi_round_sat #(
   parameter int IN_W  = 33,
   parameter int OUT_W = 12,
   parameter int SHIFT = 14
) (
   input  logic signed [IN_W-1:0]  din,
   output logic signed [OUT_W-1:0] dout
);

   localparam logic signed [IN_W:0] MAXV = (IN_W+1)'((1 << (OUT_W-1)) - 1);
   localparam logic signed [IN_W:0] MINV = ~MAXV;

   logic signed [IN_W:0] scaled;

   generate
      if (IN_W <= OUT_W) begin : g_bad_width
         $error("hbi_round_sat: IN_W must exceed OUT_W");
      end
      if (SHIFT > 0) begin : g_round
         logic signed [IN_W:0] biased;
         assign biased = (IN_W+1)'(din) + (IN_W+1)'(1 << (SHIFT-1));
         assign scaled = biased >>> SHIFT;
      end else begin : g_pass
         assign scaled = (IN_W+1)'(din);
      end
   endgenerate

   always_comb begin
      if (scaled > MAXV) begin
         dout = OUT_W'(MAXV);
      end else if (scaled < MINV) begin
         dout = OUT_W'(MINV);
      end else begin
         dout = OUT_W'(scaled);
      end
   end

endmodule

// File: rtl/halfband_interp2x.sv
module halfband_interp2x #(
   parameter int DATA_W = 12,
   parameter int COEF_W = 16
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic signed [DATA_W-1:0]  din_i,
   input  logic signed [DATA_W-1:0]  din_q,
   output logic                      take_in,
   output logic                      out_ph,
   output logic signed [DATA_W-1:0]  dout_i,
   output logic signed [DATA_W-1:0]  dout_q
);

   localparam int NHALF   = hbi_pkg::HB_NHALF;
   localparam int SHIFT   = hbi_pkg::HB_CTR_SHIFT;
   localparam int DEPTH   = 2 * NHALF;
   localparam int CTR_IDX = NHALF - 1;
   localparam int ACC_W   = DATA_W + 1 + COEF_W + $clog2(NHALF);
   localparam int NCH     = 2;

   generate
      if (DATA_W < 4 || DATA_W > 24) begin : g_bad_data_w
         $error("halfband_interp2x: DATA_W out of range 4..24");
      end
      if (COEF_W < 15) begin : g_bad_coef_w
         $error("halfband_interp2x: COEF_W must hold the largest outer tap");
      end
   endgenerate

   // slot toggle: 0 = the next edge captures inputs and loads the centre phase
   logic slot_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         slot_q <= 1'b0;
         out_ph <= 1'b0;
      end else begin
         slot_q <= ~slot_q;
         out_ph <= ~slot_q;
      end
   end

   assign take_in = ~slot_q;

   logic [NCH-1:0][DATA_W-1:0] din_ch;
   assign din_ch = {din_q, din_i};

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
         logic [DEPTH-1:0][DATA_W-1:0] taps;
         logic signed [ACC_W-1:0]      filt_acc;
         logic signed [ACC_W-1:0]      ctr_acc;
         logic signed [ACC_W-1:0]      sel_acc;
         logic signed [DATA_W-1:0]     y;
         logic signed [DATA_W-1:0]     out_q;

         hbi_delay_line #(
            .DW    (DATA_W),
            .DEPTH (DEPTH)
         ) u_dl (
            .clk      (clk),
            .rst      (rst),
            .shift_en (take_in),
            .din      (din_ch[ch]),
            .taps     (taps)
         );

         hbi_polyphase #(
            .DW    (DATA_W),
            .CW    (COEF_W),
            .NHALF (NHALF),
            .ACC_W (ACC_W)
         ) u_pp (
            .taps (taps),
            .acc  (filt_acc)
         );

         // centre phase: one tap times 2**SHIFT, a plain shift
         assign ctr_acc = ACC_W'($signed(taps[CTR_IDX])) <<< SHIFT;
         assign sel_acc = take_in ? ctr_acc : filt_acc;

         hbi_round_sat #(
            .IN_W  (ACC_W),
            .OUT_W (DATA_W),
            .SHIFT (SHIFT)
         ) u_rs (
            .din  (sel_acc),
            .dout (y)
         );

         always_ff @(posedge clk) begin
            if (rst) begin
               out_q <= '0;
            end else begin
               out_q <= y;
            end
         end
      end
   endgenerate

   assign dout_i = g_ch[0].out_q;
   assign dout_q = g_ch[1].out_q;

endmodule

// File: rtl/hbi_checker.sv
module hbi_checker #(
   parameter int DATA_W = 12
) (
   input logic                      clk,
   input logic                      rst,
   input logic signed [DATA_W-1:0]  din_i,
   input logic signed [DATA_W-1:0]  din_q,
   input logic                      take_in,
   input logic                      out_ph,
   input logic signed [DATA_W-1:0]  dout_i,
   input logic signed [DATA_W-1:0]  dout_q
);

   localparam int NHALF = hbi_pkg::HB_NHALF;
   localparam int SH_D  = NHALF + 1;

   // history of captured words, index 0 newest
   logic [SH_D-1:0][DATA_W-1:0] sh_i;
   logic [SH_D-1:0][DATA_W-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_i <= '0;
         sh_q <= '0;
      end else if (take_in) begin
         sh_i <= {sh_i[SH_D-2:0], din_i};
         sh_q <= {sh_q[SH_D-2:0], din_q};
      end
   end

   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (dout_i == '0 && dout_q == '0 && !out_ph && take_in));

   p_slot_fall_r2: assert property (@(posedge clk) disable iff (rst)
      take_in |=> !take_in);

   p_slot_rise_r2: assert property (@(posedge clk) disable iff (rst)
      !take_in |=> take_in);

   p_centre_copy_r3: assert property (@(posedge clk) disable iff (rst)
      out_ph |-> (dout_i == $signed(sh_i[NHALF])));

   p_centre_copy_q_r8: assert property (@(posedge clk) disable iff (rst)
      out_ph |-> (dout_q == $signed(sh_q[NHALF])));

   p_phase_after_capture_r7: assert property (@(posedge clk) disable iff (rst)
      take_in |=> out_ph);

   p_phase_after_filter_r7: assert property (@(posedge clk) disable iff (rst)
      !take_in |=> !out_ph);

endmodule

bind halfband_interp2x hbi_checker #(.DATA_W(DATA_W)) u_hbi_chk (
   .clk     (clk),
   .rst     (rst),
   .din_i   (din_i),
   .din_q   (din_q),
   .take_in (take_in),
   .out_ph  (out_ph),
   .dout_i  (dout_i),
   .dout_q  (dout_q)
);

// File: tb/halfband_interp2x_test.sv
module halfband_interp2x_test;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic signed [11:0] din_i = '0;
   logic signed [11:0] din_q = '0;
   wire                take_in;
   wire                out_ph;
   wire signed [11:0]  dout_i;
   wire signed [11:0]  dout_q;

   int checks   = 0;
   int failures = 0;
   int cyc      = 0;
   int n        = 0;
   int hi [0:4095];
   int hq [0:4095];
   bit lat_watch = 0;
   int lat_cap   = 0;
   int lat_seen  = -1;

   always #10 clk = ~clk;
   always @(posedge clk) cyc++;

   halfband_interp2x uut (
      .clk     (clk),
      .rst     (rst),
      .din_i   (din_i),
      .din_q   (din_q),
      .take_in (take_in),
      .out_ph  (out_ph),
      .dout_i  (dout_i),
      .dout_q  (dout_q)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d (time %0t)", tag, act, exp, $time);
      end
   endtask

   // full 43-tap response, index j = 0..42, centre at 21
   function automatic int h43(input int j);
      int pp;
      int mag;
      if (j == 21) return 16384;
      if ((j % 2) == 1) return 0;
      pp = j / 2;
      if (pp > 10) pp = 21 - pp;
      case (pp)
         0: mag = 10;    1: mag = 31;    2: mag = 69;    3: mag = 138;
         4: mag = 248;   5: mag = 419;   6: mag = 678;   7: mag = 1083;
         8: mag = 1776;  9: mag = 3282;  default: mag = 10364;
      endcase
      return (((10 - pp) % 2) == 0) ? mag : -mag;
   endfunction

   // expected output word m of the zero-stuffed, filtered stream
   task automatic yref(input int m, input bit useq, output int y, output bit half, output bit clip);
      int acc = 0;
      for (int j = 0; j < 43; j++) begin
         int k = m - j;
         if (k >= 0 && (k % 2) == 0) acc += h43(j) * (useq ? hq[k/2] : hi[k/2]);
      end
      half = ((acc & 16383) == 8192);
      y    = (acc + 8192) >>> 14;
      clip = 0;
      if (y > 2047)  begin y = 2047;  clip = 1; end
      if (y < -2048) begin y = -2048; clip = 1; end
   endtask

   task automatic check_out(input int m, input bit eph);
      int  yi, yq;
      bit  hf, cl, hfq, clq;
      string tag;
      yref(m, 1'b0, yi, hf, cl);
      yref(m, 1'b1, yq, hfq, clq);
      tag = eph ? "R3" : (cl ? "R6" : (hf ? "R5" : "R4"));
      chk(int'(dout_i) == yi, tag, dout_i, yi);
      chk(int'(dout_q) == yq, "R8", dout_q, yq);
      chk(out_ph == eph, "R7", out_ph, eph);
      if (lat_watch && eph && lat_seen < 0 && dout_i != 0) lat_seen = cyc;
   endtask

   // one capture slot: drive, then check the two words that follow
   task automatic step(input int vi, input int vq);
      chk(take_in == 1'b1, "R2", take_in, 1);
      din_i = 12'(vi);
      din_q = 12'(vq);
      hi[n] = vi;
      hq[n] = vq;
      if (lat_watch && lat_cap == 0) lat_cap = cyc + 1;
      @(posedge clk);
      @(negedge clk);
      check_out(2*n - 1, 1'b1);
      chk(take_in == 1'b0, "R2", take_in, 0);
      @(posedge clk);
      @(negedge clk);
      check_out(2*n, 1'b0);
      n++;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      din_i = 12'sd700;
      din_q = -12'sd900;
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1: outputs clear while held in reset
      chk(dout_i == 0, "R1", dout_i, 0);
      chk(dout_q == 0, "R1", dout_q, 0);
      chk(out_ph == 1'b0, "R1", out_ph, 0);
      chk(take_in == 1'b1, "R1", take_in, 1);
      rst = 1'b0;
      for (int k = 0; k < 4096; k++) begin hi[k] = 0; hq[k] = 0; end
      n = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();

      // R3 latency: single impulse on I, Q idle (R8)
      lat_watch = 1;
      step(1000, 0);
      for (int k = 0; k < 14; k++) step(0, 0);
      lat_watch = 0;
      chk(lat_seen - lat_cap == 22, "R3", lat_seen - lat_cap, 22);

      // impulse amplitude sweep on I, scaled impulses on Q
      for (int a = -2048; a < 2048; a += 64) begin
         step(a, -(a / 2));
         for (int k = 0; k < 23; k++) step(0, 0);
      end
      // exact half: -2048 against the 10364 tap rounds up to -1295 (R5)
      step(-2048, 0);
      for (int k = 0; k < 23; k++) step(0, 0);

      // R6: sign-matched full scale, both rails
      for (int r = 0; r < 2; r++) begin
         for (int k = 0; k < 22; k++) begin
            int p  = 21 - k;
            int pp = (p > 10) ? 21 - p : p;
            int s  = (((10 - pp) % 2) == 0) ? 1 : -1;
            int v  = (r == 0) ? ((s > 0) ? 2047 : -2048) : ((s > 0) ? -2048 : 2047);
            step(v, -v / 3);
         end
         for (int k = 0; k < 23; k++) step(0, 0);
      end

      // R9: DC level settles to unity gain on both phases
      for (int k = 0; k < 30; k++) step(1500, -777);
      @(negedge clk);
      chk(dout_i == 1500, "R9", dout_i, 1500);
      chk(dout_q == -777, "R9", dout_q, -777);
      @(negedge clk);
      chk(dout_i == 1500, "R9", dout_i, 1500);
      chk(dout_q == -777, "R9", dout_q, -777);

      // random streams on both channels
      do_reset();
      for (int k = 0; k < 600; k++) begin
         step(int'($urandom_range(0, 4095)) - 2048, int'($urandom_range(0, 4095)) - 2048);
      end

      // R1: reset clears history; zero input then gives zero output
      do_reset();
      for (int k = 0; k < 24; k++) step(0, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule